// File: doc/BRIEF.md
# NAK-halting transmit byte queue

This block sits between a register interface and an I2C byte engine. While it is switched on, every write to the data port is put in a queue of parameterised depth (64 bytes by default). The queue hands bytes to the engine one at a time and back to back. A byte goes out only after the engine has reported that the previous byte was acknowledged.

If the engine reports that a byte was not acknowledged, draining stops. A sticky not-acknowledged interrupt bit is raised, and the bytes that remain stay in the queue until software flushes them. The queue reports emptiness in two ways: as a live status bit, and as an interrupt bit that latches when the last queued byte has been handed off.

Control is one byte-wide write port. Bit 6 is the queue switch and bit 7 is a flush command that clears itself. Bus bit timing belongs entirely to the byte engine behind the valid/ready/done handshake.

Top module: `txq_nak_fifo`

## Requirements
- R1: After a clock edge with `rst_n` low, the block is in its reset state: queue off, flush readback 0, `level` 0, status bit 4 (empty) 1, status bit 5 (full) 0, `irq_stat` 0, `overflow` 0 and `eng_valid` 0.
- R2: While control bit 6 is 1, a `data_wr` to a queue that is not full adds one byte, so `level` rises by one after the edge. While bit 6 is 0, a `data_wr` leaves `level` unchanged.
- R3: Bytes reach the engine in write order. `eng_data` shows the oldest queued byte while `eng_valid` is 1, and it stays stable until `eng_ready` is 1. The byte leaves the queue on the edge where `eng_valid` and `eng_ready` are both 1.
- R4: After a handoff, `eng_valid` stays 0 until the engine pulses `eng_done` with `eng_nak` 0. A following byte may then be offered in the very next cycle.
- R5: `eng_done` with `eng_nak` 1 sets `irq_stat` bit 0. From then on, no byte is offered and `level` stays the same until a flush.
- R6: A control write with bit 7 set empties the queue, clears the halt and clears `overflow`. Bit 7 of `ctrl_rdata` then reads 1 for exactly one cycle. The flush takes priority over a data write in the same cycle.
- R7: A `data_wr` while the queue is on and `level` equals the depth is dropped, even if a byte leaves in the same cycle. It sets `overflow`, which stays set until a flush.
- R8: `fifo_stat` bit 4 is 1 exactly when `level` is 0, and bit 5 is 1 exactly when `level` equals the depth. All other status bits read 0.
- R9: `irq_stat` bit 1 is set on the edge where a handoff leaves the queue empty. Each `irq_stat` bit is cleared by a 1 on the matching `irq_clr` bit, and a set in the same cycle wins over the clear.
- R10: `ctrl_rdata` bit 6 reads back the switch. Turning the queue off stops new handoffs, but a byte already handed off still completes and keeps its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control value: bit 6 switch, bit 7 flush |
| ctrl_rdata | output | 8 | Control readback: bit 6 switch, bit 7 flush in progress |
| data_wr | input | 1 | Data write strobe |
| data_wdata | input | WIDTH | Byte to queue |
| fifo_stat | output | 8 | Bit 4 empty, bit 5 full |
| irq_stat | output | 2 | Bit 0 not-acknowledged, bit 1 queue drained |
| irq_clr | input | 2 | Write-one-to-clear for `irq_stat` |
| overflow | output | 1 | Sticky dropped-write flag |
| level | output | $clog2(DEPTH+1) | Number of queued bytes |
| eng_valid | output | 1 | Byte offered to the engine |
| eng_data | output | WIDTH | Offered byte |
| eng_ready | input | 1 | Engine takes the offered byte |
| eng_done | input | 1 | Engine finished the byte in flight |
| eng_nak | input | 1 | Acknowledge bit sampled with `eng_done` (1 = not acknowledged) |

## Verification
The hardest state to reach is a halt with bytes still queued behind the byte that was refused. The stimulus reaches it by loading several bytes while the engine model holds `eng_ready` low. It then arms a not-acknowledge on a chosen handoff number and releases `eng_ready`, so the halt lands mid-queue. The bench then idles long enough to show that nothing more is offered, before flushing and refilling. Overflow is reached the same way: the queue is filled past its depth while the engine stalls.

// File: rtl/txq_pkg.sv
// Shared constants and types for the NAK-halting transmit queue.
// Assumes: byte-wide control and status words.
package txq_pkg;
    localparam int CTRL_EN_BIT    = 6;
    localparam int CTRL_FLUSH_BIT = 7;
    localparam int STAT_EMPTY_BIT = 4;
    localparam int STAT_FULL_BIT  = 5;
    localparam int IRQ_NAK_BIT    = 0;
    localparam int IRQ_EMPTY_BIT  = 1;
    localparam int IRQ_BITS       = 2;

    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_BUSY = 2'd1,
        DR_HALT = 2'd2
    } drain_state_e;
endpackage

// File: rtl/txq_store.sv
// Circular byte store with occupancy count.
// Assumes: the caller never pushes when full nor pops when empty;
// clear resets both pointers and the count in one edge.
module txq_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [LW-1:0]    count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and count update, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wrap_inc(wr_ptr);
            if (pop)  rd_ptr <= wrap_inc(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head byte and occupancy flags.
    always_comb begin
        head_data = mem[rd_ptr];
        empty     = (count == '0);
        full      = (count == LW'(DEPTH));
    end
endmodule

// File: rtl/txq_drain.sv
// Drain sequencer: offers one byte at a time, waits for the engine's
// completion, and halts on a not-acknowledge until a flush.
// Assumes: eng_done is only pulsed while a byte is in flight.
module txq_drain
    import txq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clear,
    input  logic empty,
    input  logic eng_ready,
    input  logic eng_done,
    input  logic eng_nak,
    output logic eng_valid,
    output logic pop,
    output logic nak_event
);
    drain_state_e state_q, state_d;

    // Handshake outputs decoded from the current state.
    always_comb begin
        eng_valid = (state_q == DR_IDLE) && enable && !empty;
        pop       = eng_valid && eng_ready;
        nak_event = (state_q == DR_BUSY) && eng_done && eng_nak;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            DR_IDLE: if (pop) state_d = DR_BUSY;
            DR_BUSY: if (eng_done) state_d = (eng_nak && !clear) ? DR_HALT : DR_IDLE;
            DR_HALT: if (clear) state_d = DR_IDLE;
            default: state_d = DR_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/txq_flags.sv
// Sticky interrupt bits (set wins over clear) and the overflow flag.
// Assumes: pop and push are the accepted transfers of this cycle.
module txq_flags
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                pop,
    input  logic                push,
    input  logic [LW-1:0]       count,
    input  logic                nak_event,
    input  logic                ovf_event,
    input  logic [IRQ_BITS-1:0] irq_clr,
    output logic [IRQ_BITS-1:0] irq_stat,
    output logic                overflow
);
    logic [IRQ_BITS-1:0] irq_set;

    // Interrupt causes mapped to their bit positions.
    always_comb begin
        irq_set                = '0;
        irq_set[IRQ_NAK_BIT]   = nak_event;
        irq_set[IRQ_EMPTY_BIT] = pop && !push && !clear && (count == LW'(1));
    end

    // One sticky register per interrupt bit.
    for (genvar i = 0; i < IRQ_BITS; i++) begin : g_irq
        always_ff @(posedge clk) begin
            if (!rst_n)          irq_stat[i] <= 1'b0;
            else if (irq_set[i]) irq_stat[i] <= 1'b1;
            else if (irq_clr[i]) irq_stat[i] <= 1'b0;
        end
    end

    // Overflow stays set until reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) overflow <= 1'b0;
        else if (ovf_event)  overflow <= 1'b1;
    end
endmodule

// File: rtl/txq_nak_fifo.sv
// Transmit queue top: control decode, store, drain sequencer and flags.
// Assumes: a byte engine behind eng_valid/eng_ready/eng_done handles
// all bus timing and reports the sampled acknowledge with eng_done.
module txq_nak_fifo
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [7:0]          ctrl_wdata,
    output logic [7:0]          ctrl_rdata,
    input  logic                data_wr,
    input  logic [WIDTH-1:0]    data_wdata,
    output logic [7:0]          fifo_stat,
    output logic [IRQ_BITS-1:0] irq_stat,
    input  logic [IRQ_BITS-1:0] irq_clr,
    output logic                overflow,
    output logic [LW-1:0]       level,
    output logic                eng_valid,
    output logic [WIDTH-1:0]    eng_data,
    input  logic                eng_ready,
    input  logic                eng_done,
    input  logic                eng_nak
);
    logic en_q;
    logic flush_q;
    logic clear;
    logic push;
    logic pop;
    logic ovf_event;
    logic nak_event;
    logic empty;
    logic full;

    // Decode of this cycle's control and data writes.
    always_comb begin
        clear     = ctrl_wr && ctrl_wdata[CTRL_FLUSH_BIT];
        push      = data_wr && en_q && !full && !clear;
        ovf_event = data_wr && en_q && full && !clear;
    end

    // Switch register and the flush bit that lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= clear;
            if (ctrl_wr) en_q <= ctrl_wdata[CTRL_EN_BIT];
        end
    end

    txq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (push),
        .push_data (data_wdata),
        .pop       (pop),
        .head_data (eng_data),
        .count     (level),
        .empty     (empty),
        .full      (full)
    );

    txq_drain u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (en_q),
        .clear     (clear),
        .empty     (empty),
        .eng_ready (eng_ready),
        .eng_done  (eng_done),
        .eng_nak   (eng_nak),
        .eng_valid (eng_valid),
        .pop       (pop),
        .nak_event (nak_event)
    );

    txq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .pop       (pop),
        .push      (push),
        .count     (level),
        .nak_event (nak_event),
        .ovf_event (ovf_event),
        .irq_clr   (irq_clr),
        .irq_stat  (irq_stat),
        .overflow  (overflow)
    );

    // Readback words assembled from their bit positions.
    always_comb begin
        ctrl_rdata                 = '0;
        ctrl_rdata[CTRL_EN_BIT]    = en_q;
        ctrl_rdata[CTRL_FLUSH_BIT] = flush_q;
        fifo_stat                  = '0;
        fifo_stat[STAT_EMPTY_BIT]  = empty;
        fifo_stat[STAT_FULL_BIT]   = full;
    end
endmodule

// File: rtl/txq_nak_fifo_chk.sv
// Port-level protocol checks for txq_nak_fifo, attached by bind.
module txq_nak_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic [7:0]       ctrl_wdata,
    input logic [7:0]       ctrl_rdata,
    input logic             data_wr,
    input logic [7:0]       fifo_stat,
    input logic [1:0]       irq_stat,
    input logic             overflow,
    input logic [LW-1:0]    level,
    input logic             eng_valid,
    input logic [WIDTH-1:0] eng_data,
    input logic             eng_ready,
    input logic             eng_done,
    input logic             eng_nak
);
    a_r3_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_ready && !ctrl_wr) |=> (eng_valid && $stable(eng_data)));

    a_r4_single_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && eng_ready) |=> !eng_valid);

    a_r5_nak_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_nak && !ctrl_wr) |=> (irq_stat[0] && !eng_valid));

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[7]) |=> (level == '0 && ctrl_rdata[7] && !overflow));

    a_r6_flush_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[7] && !(ctrl_wr && ctrl_wdata[7])) |=> !ctrl_rdata[7]);

    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ctrl_rdata[6] && int'(level) == DEPTH && !(eng_valid && eng_ready) && !ctrl_wr)
        |=> ($stable(level) && overflow));

    a_r8_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_stat[4] == (level == '0));

    a_r9_drain_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && eng_ready && level == LW'(1) && !data_wr && !ctrl_wr) |=> irq_stat[1]);
endmodule

bind txq_nak_fifo txq_nak_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .data_wr    (data_wr),
    .fifo_stat  (fifo_stat),
    .irq_stat   (irq_stat),
    .overflow   (overflow),
    .level      (level),
    .eng_valid  (eng_valid),
    .eng_data   (eng_data),
    .eng_ready  (eng_ready),
    .eng_done   (eng_done),
    .eng_nak    (eng_nak)
);

// File: tb/sim_txq_nak_fifo.sv
module sim_txq_nak_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int LW         = $clog2(DEPTH + 1);
    localparam int WDOG       = 150000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctrl_wr;
    logic [7:0]    ctrl_wdata;
    logic [7:0]    ctrl_rdata;
    logic          data_wr;
    logic [7:0]    data_wdata;
    logic [7:0]    fifo_stat;
    logic [1:0]    irq_stat;
    logic [1:0]    irq_clr;
    logic          overflow;
    logic [LW-1:0] level;
    logic          eng_valid;
    logic [7:0]    eng_data;
    logic          eng_ready;
    logic          eng_done = 1'b0;
    logic          eng_nak  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txq_nak_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .data_wr(data_wr), .data_wdata(data_wdata),
        .fifo_stat(fifo_stat), .irq_stat(irq_stat), .irq_clr(irq_clr),
        .overflow(overflow), .level(level), .eng_valid(eng_valid),
        .eng_data(eng_data), .eng_ready(eng_ready), .eng_done(eng_done),
        .eng_nak(eng_nak)
    );

    // Reference model state (written only by the posedge model process).
    logic [7:0] m_q[$];
    bit   m_en, m_flush, m_halt, m_busy, m_ovf, m_started;
    bit   [1:0] m_irq;
    bit   e_busy, e_cur_nak;
    int   e_cnt, e_sent;
    // Stimulus knobs (written only by the initial block).
    int   e_lat;
    int   nak_at;
    // Bench counters (written only by the negedge checker).
    int   checks, errors, cyc;

    function automatic bit m_valid_f();
        return m_en && !m_halt && !m_busy && (m_q.size() != 0);
    endfunction

    // Reference model and engine model, advanced on every rising edge.
    always @(posedge clk) begin
        bit hs, flush, wen, wfull;
        int pre;
        if (!rst_n) begin
            m_q.delete();
            m_en = 0; m_flush = 0; m_halt = 0; m_busy = 0; m_ovf = 0; m_irq = 0;
            e_busy = 0; e_cnt = 0; e_sent = 0; e_cur_nak = 0;
            m_started = 1;
        end else begin
            hs    = m_valid_f() && eng_ready;
            flush = ctrl_wr && ctrl_wdata[7];
            wen   = data_wr && m_en;
            pre   = m_q.size();
            wfull = (pre == DEPTH);
            m_irq = m_irq & ~irq_clr;
            if (m_busy && eng_done && eng_nak) m_irq[0] = 1;
            if (hs && !flush && pre == 1 && !(wen && !wfull)) m_irq[1] = 1;
            if (m_busy && eng_done) begin
                m_busy = 0;
                if (eng_nak) m_halt = 1;
            end
            if (flush) m_halt = 0;
            if (hs) m_busy = 1;
            if (flush) begin
                m_q.delete();
                m_ovf = 0;
            end else begin
                if (hs) void'(m_q.pop_front());
                if (wen) begin
                    if (wfull) m_ovf = 1;
                    else m_q.push_back(data_wdata);
                end
            end
            m_flush = flush;
            if (ctrl_wr) m_en = ctrl_wdata[6];
            if (hs) begin
                e_busy = 1; e_cnt = e_lat; e_sent++;
                e_cur_nak = (e_sent == nak_at);
            end else if (e_busy && eng_done) begin
                e_busy = 0;
            end else if (e_busy && e_cnt > 0) begin
                e_cnt--;
            end
        end
    end

    // Engine completion pulse driven away from the rising edge.
    always @(negedge clk) begin
        eng_done <= e_busy && (e_cnt == 0);
        eng_nak  <= e_busy && (e_cnt == 0) && e_cur_nak;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Compare the design against the model on every falling edge.
    always @(negedge clk) begin
        string r_;
        cyc++;
        if (m_started) begin
            if (!rst_n) begin
                chk("R1", "valid", int'(eng_valid), 0);
                chk("R1", "level", int'(level), 0);
                chk("R1", "irq", int'(irq_stat), 0);
                chk("R1", "overflow", int'(overflow), 0);
                chk("R1", "ctrl", int'(ctrl_rdata), 0);
                chk("R1", "empty bit", int'(fifo_stat[4]), 1);
            end else begin
                chk("R4,R10", "eng_valid", int'(eng_valid), int'(m_valid_f()));
                if (m_valid_f()) chk("R3", "eng_data", int'(eng_data), int'(m_q[0]));
                chk("R2", "level", int'(level), m_q.size());
                chk("R8", "empty bit", int'(fifo_stat[4]), int'(m_q.size() == 0));
                chk("R8", "full bit", int'(fifo_stat[5]), int'(m_q.size() == DEPTH));
                chk("R8", "other status bits", int'(fifo_stat & 8'hCF), 0);
                chk("R5", "nak irq", int'(irq_stat[0]), int'(m_irq[0]));
                chk("R9", "drain irq", int'(irq_stat[1]), int'(m_irq[1]));
                chk("R7", "overflow", int'(overflow), int'(m_ovf));
                chk("R6", "flush readback", int'(ctrl_rdata[7]), int'(m_flush));
                chk("R10", "switch readback", int'(ctrl_rdata[6]), int'(m_en));
            end
        end
        if (cyc > WDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_bytes(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); data_wr = 1'b1; data_wdata = 8'(seed + i * 37);
        end
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic clr_irq(input logic [1:0] m);
        @(negedge clk); irq_clr = m;
        @(negedge clk); irq_clr = 2'b00;
    endtask

    initial begin
        rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = '0; data_wr = 1'b0;
        data_wdata = '0; irq_clr = '0; eng_ready = 1'b0; e_lat = 1; nak_at = 0;
        idle(3);
        rst_n = 1'b1;
        // R2: writes while switched off are ignored.
        wr_bytes(3, 5);
        idle(2);
        // R2 R3 R4 R9: queue while stalled, then drain in order.
        ctrl(8'h40);
        wr_bytes(5, 11);
        idle(3);
        eng_ready = 1'b1;
        idle(30);
        clr_irq(2'b11);
        // R7 R6: overfill while stalled, then flush.
        eng_ready = 1'b0;
        wr_bytes(DEPTH + 2, 90);
        idle(2);
        ctrl(8'hC0);
        idle(3);
        // R5: not-acknowledge on the second handoff halts with bytes left.
        e_lat = 2;
        wr_bytes(4, 200);
        nak_at = e_sent + 2;
        eng_ready = 1'b1;
        idle(40);
        clr_irq(2'b11);
        idle(2);
        ctrl(8'hC0);
        wr_bytes(3, 61);
        idle(30);
        // R10: switching off mid-drain stops new handoffs.
        e_lat = 6;
        wr_bytes(3, 150);
        idle(2);
        ctrl(8'h00);
        idle(20);
        ctrl(8'h40);
        idle(40);
        // Back-to-back with zero engine latency and a write while draining.
        e_lat = 0;
        wr_bytes(6, 33);
        idle(30);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule